// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block feeds the transmit FIFO of a serial channel from buffers that software describes in a circular table of descriptors. The table lives in a local dual-port RAM. Each entry is four 16-bit words: a status/control word, a byte count, and the high and low halves of a buffer pointer. While nothing is pending, the engine keeps reading the status word of its current entry. When software marks that entry ready, the engine loads the rest of the entry and reads the buffer one byte at a time. It passes each byte to the FIFO, then writes the status word back to tell software the buffer is finished.

A buffer can sit either in the local RAM, reached through an 11-bit byte offset, or in external memory, reached through a 24-bit address that goes out together with a function-code value. A frame may cover several entries, and software may add the later entries while the frame is already being sent. If an entry the frame needs is still not ready once the frame has started, the engine reports an underrun. It then discards the rest of that frame, up to the entry that closes it.

Top module: `txbd_ring_engine`

## Requirements
- R1: Entry n of the table starts at internal word address TBL_BASE + 4*n. Its words, in order, are status/control, byte count, pointer high and pointer low. The engine reads the status word of its current entry repeatedly and starts on the entry only when status bit 15 (ready) is 1.
- R2: For a ready entry the engine pushes exactly as many bytes as the byte count, in ascending address order. In internal RAM an even byte offset selects bits 15:8 of the word and an odd offset selects bits 7:0.
- R3: When status bit 12 is 0 the buffer is internal. Its byte offset is pointer-low bits 10:0, the word read is offset bits 10:1, and the pointer-high word is ignored.
- R4: When status bit 12 is 1 the buffer is external, at address {pointer-high[7:0], pointer-low}, incremented per byte. ext_req stays high with a stable address until ext_ack, and ext_fc carries the function-code value.
- R5: After a buffer the engine writes the status word back with bit 15 cleared, bit 1 set to the underrun result and all other bits unchanged. In the same cycle it pulses bd_done for exactly one cycle.
- R6: After an entry with status bit 13 (wrap) set, the next entry is 0. After entry N_BD-1 the next entry is also 0. Otherwise the next entry is the current one plus 1.
- R7: Status bit 11 (last) marks the final entry of a frame. fifo_last is high only together with the final byte of such an entry. An entry added late continues the frame with no error, provided it is ready by the time the engine reads it.
- R8: If the status word of the current entry shows not-ready after at least one byte of the current frame has been pushed, underrun pulses for one cycle. Polling before the first byte of a frame never raises underrun.
- R9: After an underrun, each following ready entry, up to and including the next one with bit 11 set, is written back with bit 15 cleared and bit 1 set, with a bd_done pulse and no bytes pushed. Normal operation then resumes.
- R10: A write on fc_we changes the function-code value only while the engine is polling between frames. At any other time the write is ignored.
- R11: fifo_wr is never high while fifo_full is high. A byte waits in the engine until the FIFO has room.
- R12: After reset the engine is at entry 0 and fifo_wr, bd_done, ext_req and underrun are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_rd_en | output | 1 | Internal RAM read strobe; data is returned on the following cycle |
| int_wr_en | output | 1 | Internal RAM write strobe (status write-back) |
| int_addr | output | INT_AW | Internal RAM word address |
| int_wdata | output | 16 | Internal RAM write data |
| int_rdata | input | 16 | Internal RAM read data, one cycle after int_rd_en |
| ext_req | output | 1 | External byte read request, held until ext_ack |
| ext_addr | output | EXT_AW | External byte address |
| ext_fc | output | FCW | Function-code value sent with external accesses |
| ext_rdata | input | 8 | External read data, valid with ext_ack |
| ext_ack | input | 1 | External read completion |
| fifo_wr | output | 1 | Push strobe to the transmit FIFO |
| fifo_data | output | 8 | Byte pushed to the FIFO |
| fifo_last | output | 1 | Pushed byte ends the frame |
| fifo_full | input | 1 | FIFO cannot take a byte |
| fc_we | input | 1 | Function-code register write strobe |
| fc_wdata | input | FCW | Function-code register write value |
| bd_done | output | 1 | One-cycle pulse when an entry is written back |
| underrun | output | 1 | One-cycle pulse when a frame is aborted because an entry was not ready |

## Verification
The checker watches the properties that hold on every clock cycle. These are FIFO backpressure, the one-cycle shape of bd_done and underrun, the cleared ready bit in every status write-back, fifo_last only on a push, and an external request that holds its address and function code until it is acknowledged. The bench scenarios cover what depends on the contents of the table and on sequences of events. These are the byte order and address form of internal and external buffers, the index stepping through both wrap paths, and a frame continued by an entry added late. They also cover an underrun followed by discarding the rest of that frame, and a function-code write dropped during a transfer but accepted while the engine is polling.

// File: rtl/txbd_pkg.sv
// Package: shared constants and state type for the transmit descriptor ring engine.
// Assumes 16-bit descriptor words and the status bit layout listed here.
package txbd_pkg;

    // Status/control word bit positions
    localparam int BIT_READY = 15;
    localparam int BIT_WRAP  = 13;
    localparam int BIT_EXT   = 12;
    localparam int BIT_LAST  = 11;
    localparam int BIT_UR    = 1;

    // Word offsets inside one descriptor
    localparam logic [1:0] WSEL_STAT = 2'd0;
    localparam logic [1:0] WSEL_LEN  = 2'd1;
    localparam logic [1:0] WSEL_PHI  = 2'd2;
    localparam logic [1:0] WSEL_PLO  = 2'd3;

    typedef enum logic [3:0] {
        S_ST,    // issue status read
        S_LEN,   // check status, issue length read
        S_HI,    // take length, issue pointer-high read
        S_LO,    // take pointer-high, issue pointer-low read
        S_ADR,   // take pointer-low, form start pointer
        S_NEXT,  // decide: more bytes or write-back
        S_IRD,   // issue internal byte read
        S_IDAT,  // capture internal byte
        S_EXT,   // external request until ack
        S_PUSH,  // push held byte when FIFO has room
        S_WB     // status write-back
    } eng_state_e;

endpackage

// File: rtl/txbd_fc_reg.sv
// Function-code register for external buffer accesses.
// A write takes effect only when the engine reports that it is idle between frames;
// writes at any other time are dropped.
module txbd_fc_reg #(
    parameter int FCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           idle,
    input  logic           we,
    input  logic [FCW-1:0] wdata,
    output logic [FCW-1:0] fc
);

    logic [FCW-1:0] fc_q;

    // Hold the function code; accept writes only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fc_q <= '0;
        end else if (we && idle) begin
            fc_q <= wdata;
        end
    end

    assign fc = fc_q;

endmodule

// File: rtl/txbd_addr_map.sv
// Buffer address former. Builds the start pointer from the two pointer words
// (internal: 11-bit byte offset, external: EXT_AW-bit address), and maps the
// running pointer to an internal word address and byte lane.
// Assumes OFFW = INT_AW+1 <= EXT_AW <= 32 and big-endian byte lanes.
module txbd_addr_map #(
    parameter int INT_AW = 10,
    parameter int EXT_AW = 24
) (
    input  logic              is_ext,
    input  logic [15:0]       ptr_hi,
    input  logic [15:0]       ptr_lo,
    input  logic [EXT_AW-1:0] ptr,
    input  logic [15:0]       rword,
    output logic [EXT_AW-1:0] start_ptr,
    output logic [INT_AW-1:0] int_word,
    output logic [7:0]        int_byte
);

    localparam int OFFW = INT_AW + 1;

    logic [31:0] joined;

    assign joined = {ptr_hi, ptr_lo};

    // Select the start pointer form from the external/internal flag.
    always_comb begin
        if (is_ext) begin
            start_ptr = joined[EXT_AW-1:0];
        end else begin
            start_ptr = EXT_AW'(ptr_lo[OFFW-1:0]);
        end
    end

    generate
        if (EXT_AW < 32) begin : g_drop_hi
            logic unused_hi;
            assign unused_hi = ^joined[31:EXT_AW];
        end
    endgenerate

    assign int_word = ptr[OFFW-1:1];
    assign int_byte = ptr[0] ? rword[7:0] : rword[15:8];

endmodule

// File: rtl/txbd_bd_index.sv
// Descriptor index keeper. Holds the current table entry, steps it after each
// write-back (to 0 on a wrap request or after the final entry), and forms the
// internal word address of a selected word of the current entry.
module txbd_bd_index #(
    parameter int N_BD     = 8,
    parameter int INT_AW   = 10,
    parameter int TBL_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              wrap_req,
    input  logic [1:0]        word_sel,
    output logic [INT_AW-1:0] word_addr
);

    localparam int IDXW = (N_BD > 1) ? $clog2(N_BD) : 1;
    localparam logic [IDXW-1:0] IDX_MAX = IDXW'(N_BD - 1);

    logic [IDXW-1:0] idx_q;

    // Step the entry index after each completed descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (advance) begin
            if (wrap_req || (idx_q == IDX_MAX)) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign word_addr = INT_AW'(TBL_BASE) + INT_AW'({idx_q, 2'b00}) + INT_AW'(word_sel);

endmodule

// File: rtl/txbd_ring_engine.sv
// Transmit descriptor ring engine (top).
// Polls the current table entry, loads a ready descriptor, streams its buffer
// bytes into the transmit FIFO from internal RAM (fixed one-cycle read latency,
// no handshake) or external memory (req/ack), and writes the status back.
// Flags an underrun when a frame in progress meets a not-ready entry and then
// discards entries up to the one closing the frame.
// Assumes the internal RAM returns read data exactly one cycle after int_rd_en.
module txbd_ring_engine
    import txbd_pkg::*;
#(
    parameter int N_BD     = 8,
    parameter int INT_AW   = 10,
    parameter int TBL_BASE = 0,
    parameter int FCW      = 3,
    parameter int EXT_AW   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              int_rd_en,
    output logic              int_wr_en,
    output logic [INT_AW-1:0] int_addr,
    output logic [15:0]       int_wdata,
    input  logic [15:0]       int_rdata,
    output logic              ext_req,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [FCW-1:0]    ext_fc,
    input  logic [7:0]        ext_rdata,
    input  logic              ext_ack,
    output logic              fifo_wr,
    output logic [7:0]        fifo_data,
    output logic              fifo_last,
    input  logic              fifo_full,
    input  logic              fc_we,
    input  logic [FCW-1:0]    fc_wdata,
    output logic              bd_done,
    output logic              underrun
);

    eng_state_e        state_q;
    logic [15:0]       st_q;
    logic [15:0]       len_q;
    logic [15:0]       hi_q;
    logic [15:0]       cnt_q;
    logic [EXT_AW-1:0] ptr_q;
    logic [7:0]        byte_q;
    logic              in_frame_q;
    logic              skip_q;
    logic              ur_q;

    logic              idle;
    logic              advance;
    logic [1:0]        word_sel;
    logic [INT_AW-1:0] desc_addr;
    logic [EXT_AW-1:0] start_ptr;
    logic [INT_AW-1:0] buf_word;
    logic [7:0]        buf_byte;
    logic              status_ready;

    assign status_ready = int_rdata[BIT_READY];

    // Engine counts as idle while polling with no frame open or being discarded.
    assign idle = ((state_q == S_ST) || (state_q == S_LEN)) && !in_frame_q && !skip_q;

    assign advance = (state_q == S_WB);

    txbd_fc_reg #(
        .FCW (FCW)
    ) fc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .idle  (idle),
        .we    (fc_we),
        .wdata (fc_wdata),
        .fc    (ext_fc)
    );

    txbd_bd_index #(
        .N_BD     (N_BD),
        .INT_AW   (INT_AW),
        .TBL_BASE (TBL_BASE)
    ) idx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .wrap_req  (st_q[BIT_WRAP]),
        .word_sel  (word_sel),
        .word_addr (desc_addr)
    );

    txbd_addr_map #(
        .INT_AW (INT_AW),
        .EXT_AW (EXT_AW)
    ) map_i (
        .is_ext    (st_q[BIT_EXT]),
        .ptr_hi    (hi_q),
        .ptr_lo    (int_rdata),
        .ptr       (ptr_q),
        .rword     (int_rdata),
        .start_ptr (start_ptr),
        .int_word  (buf_word),
        .int_byte  (buf_byte)
    );

    // Pick which descriptor word the current state addresses.
    always_comb begin
        unique case (state_q)
            S_LEN:   word_sel = WSEL_LEN;
            S_HI:    word_sel = WSEL_PHI;
            S_LO:    word_sel = WSEL_PLO;
            default: word_sel = WSEL_STAT;
        endcase
    end

    // Drive the internal RAM port: descriptor words or buffer words.
    always_comb begin
        int_rd_en = (state_q == S_ST) || (state_q == S_LEN) || (state_q == S_HI) ||
                    (state_q == S_LO) || (state_q == S_IRD);
        int_wr_en = (state_q == S_WB);
        int_addr  = (state_q == S_IRD) ? buf_word : desc_addr;
        int_wdata = st_q;
        int_wdata[BIT_READY] = 1'b0;
        int_wdata[BIT_UR]    = ur_q;
    end

    // Drive external request, FIFO push and event pulses.
    always_comb begin
        ext_req   = (state_q == S_EXT);
        ext_addr  = ptr_q;
        fifo_wr   = (state_q == S_PUSH) && !fifo_full;
        fifo_data = byte_q;
        fifo_last = fifo_wr && st_q[BIT_LAST] && ((cnt_q + 16'd1) == len_q);
        bd_done   = (state_q == S_WB);
        underrun  = (state_q == S_LEN) && !status_ready && in_frame_q && !skip_q;
    end

    // Main sequencer: poll, load descriptor, move bytes, write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_ST;
            st_q       <= '0;
            len_q      <= '0;
            hi_q       <= '0;
            cnt_q      <= '0;
            ptr_q      <= '0;
            byte_q     <= '0;
            in_frame_q <= 1'b0;
            skip_q     <= 1'b0;
            ur_q       <= 1'b0;
        end else begin
            unique case (state_q)
                S_ST: begin
                    state_q <= S_LEN;
                end
                S_LEN: begin
                    if (!status_ready) begin
                        state_q <= S_ST;
                        if (in_frame_q && !skip_q) begin
                            in_frame_q <= 1'b0;
                            skip_q     <= 1'b1;
                        end
                    end else begin
                        st_q <= int_rdata;
                        if (skip_q) begin
                            ur_q    <= 1'b1;
                            state_q <= S_WB;
                        end else begin
                            state_q <= S_HI;
                        end
                    end
                end
                S_HI: begin
                    len_q   <= int_rdata;
                    state_q <= S_LO;
                end
                S_LO: begin
                    hi_q    <= int_rdata;
                    state_q <= S_ADR;
                end
                S_ADR: begin
                    ptr_q   <= start_ptr;
                    cnt_q   <= '0;
                    ur_q    <= 1'b0;
                    state_q <= S_NEXT;
                end
                S_NEXT: begin
                    if (cnt_q == len_q) begin
                        state_q <= S_WB;
                    end else if (st_q[BIT_EXT]) begin
                        state_q <= S_EXT;
                    end else begin
                        state_q <= S_IRD;
                    end
                end
                S_IRD: begin
                    state_q <= S_IDAT;
                end
                S_IDAT: begin
                    byte_q  <= buf_byte;
                    state_q <= S_PUSH;
                end
                S_EXT: begin
                    if (ext_ack) begin
                        byte_q  <= ext_rdata;
                        state_q <= S_PUSH;
                    end
                end
                S_PUSH: begin
                    if (!fifo_full) begin
                        cnt_q      <= cnt_q + 16'd1;
                        ptr_q      <= ptr_q + 1'b1;
                        in_frame_q <= 1'b1;
                        state_q    <= S_NEXT;
                    end
                end
                S_WB: begin
                    if (st_q[BIT_LAST]) begin
                        in_frame_q <= 1'b0;
                        skip_q     <= 1'b0;
                    end
                    state_q <= S_ST;
                end
                default: begin
                    state_q <= S_ST;
                end
            endcase
        end
    end

endmodule

// File: rtl/txbd_ring_engine_chk.sv
// Checker for the transmit descriptor ring engine, attached by bind.
// Observes ports only; every property is disabled during reset.
module txbd_ring_engine_chk #(
    parameter int FCW    = 3,
    parameter int EXT_AW = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_wr,
    input logic              fifo_full,
    input logic              fifo_last,
    input logic              bd_done,
    input logic              int_wr_en,
    input logic [15:0]       int_wdata,
    input logic              ext_req,
    input logic              ext_ack,
    input logic [EXT_AW-1:0] ext_addr,
    input logic [FCW-1:0]    ext_fc,
    input logic              underrun
);

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !fifo_full) else $error("push while FIFO full"); // R11

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bd_done |=> !bd_done) else $error("done pulse longer than one cycle"); // R5

    AST_WB_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        int_wr_en |-> (!int_wdata[15] && bd_done)) else $error("write-back keeps ready set"); // R5

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr))) else $error("external request dropped or moved"); // R4

    AST_FC_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && $past(ext_req)) |-> $stable(ext_fc)) else $error("function code changed during transfer"); // R10

    AST_LAST_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_last |-> fifo_wr) else $error("end marker without push"); // R7

    AST_UR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (!fifo_wr && !bd_done && !ext_req)) else $error("underrun during transfer"); // R8

    AST_UR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun) else $error("underrun pulse longer than one cycle"); // R8

endmodule

bind txbd_ring_engine txbd_ring_engine_chk #(
    .FCW    (FCW),
    .EXT_AW (EXT_AW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_wr   (fifo_wr),
    .fifo_full (fifo_full),
    .fifo_last (fifo_last),
    .bd_done   (bd_done),
    .int_wr_en (int_wr_en),
    .int_wdata (int_wdata),
    .ext_req   (ext_req),
    .ext_ack   (ext_ack),
    .ext_addr  (ext_addr),
    .ext_fc    (ext_fc),
    .underrun  (underrun)
);

// File: tb/txbd_ring_engine_tb_top.sv
// Directed bench for the transmit descriptor ring engine.
// Models the internal RAM (one-cycle read), external memory (ack one cycle
// after request) and a FIFO sink with controllable full flag.
module txbd_ring_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int INT_AW     = 10;
    localparam int FCW        = 3;
    localparam int EXT_AW     = 24;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              int_rd_en;
    logic              int_wr_en;
    logic [INT_AW-1:0] int_addr;
    logic [15:0]       int_wdata;
    logic [15:0]       int_rdata;
    logic              ext_req;
    logic [EXT_AW-1:0] ext_addr;
    logic [FCW-1:0]    ext_fc;
    logic [7:0]        ext_rdata;
    logic              ext_ack;
    logic              fifo_wr;
    logic [7:0]        fifo_data;
    logic              fifo_last;
    logic              fifo_full;
    logic              fc_we;
    logic [FCW-1:0]    fc_wdata;
    logic              bd_done;
    logic              underrun;

    logic              tb_we;
    logic [INT_AW-1:0] tb_addr;
    logic [15:0]       tb_wdata;
    logic [15:0]       mem [0:1023];

    int n_chk  = 0;
    int n_fail = 0;
    int done_cnt = 0;
    int ur_cnt   = 0;
    int wb_cnt   = 0;
    int bad_push = 0;
    logic [7:0]        rx_b [$];
    logic              rx_l [$];
    logic [EXT_AW-1:0] xa_q [$];
    logic [FCW-1:0]    xf_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    txbd_ring_engine #(
        .N_BD     (8),
        .INT_AW   (INT_AW),
        .TBL_BASE (0),
        .FCW      (FCW),
        .EXT_AW   (EXT_AW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_rd_en (int_rd_en),
        .int_wr_en (int_wr_en),
        .int_addr  (int_addr),
        .int_wdata (int_wdata),
        .int_rdata (int_rdata),
        .ext_req   (ext_req),
        .ext_addr  (ext_addr),
        .ext_fc    (ext_fc),
        .ext_rdata (ext_rdata),
        .ext_ack   (ext_ack),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .fifo_last (fifo_last),
        .fifo_full (fifo_full),
        .fc_we     (fc_we),
        .fc_wdata  (fc_wdata),
        .bd_done   (bd_done),
        .underrun  (underrun)
    );

    function automatic logic [15:0] pat(input int i);
        logic [7:0] b;
        b = i[7:0];
        return {b ^ 8'hC3, b + 8'h11};
    endfunction

    function automatic logic [7:0] ibyte(input int a);
        logic [15:0] w;
        w = pat(a >> 1);
        return a[0] ? w[7:0] : w[15:8];
    endfunction

    // Internal RAM model: table area zeroed, data area patterned at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) begin
                mem[i] <= (i < 32) ? 16'h0000 : pat(i);
            end
            int_rdata <= '0;
        end else begin
            if (int_wr_en) mem[int_addr] <= int_wdata;
            if (tb_we)     mem[tb_addr]  <= tb_wdata;
            if (int_rd_en) int_rdata     <= mem[int_addr];
        end
    end

    // External memory model: ack one cycle after request, data from address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_ack   <= 1'b0;
            ext_rdata <= '0;
        end else begin
            ext_ack   <= ext_req && !ext_ack;
            ext_rdata <= ext_addr[7:0] ^ 8'h5A;
        end
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_wr) begin
                rx_b.push_back(fifo_data);
                rx_l.push_back(fifo_last);
                if (fifo_full) bad_push++;
            end
            if (bd_done)   done_cnt++;
            if (underrun)  ur_cnt++;
            if (int_wr_en) wb_cnt++;
            if (ext_req && ext_ack) begin
                xa_q.push_back(ext_addr);
                xf_q.push_back(ext_fc);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_word(input int a, input logic [15:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = INT_AW'(a); tb_wdata = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic set_bd(input int idx, input logic [15:0] st, input logic [15:0] len,
                          input logic [15:0] hi, input logic [15:0] lo);
        wr_word(idx*4 + 1, len);
        wr_word(idx*4 + 2, hi);
        wr_word(idx*4 + 3, lo);
        wr_word(idx*4 + 0, st);
    endtask

    task automatic fc_write(input logic [FCW-1:0] v);
        @(negedge clk);
        fc_we = 1'b1; fc_wdata = v;
        @(negedge clk);
        fc_we = 1'b0;
    endtask

    task automatic wait_done(input int target, input string tag);
        int k;
        k = 0;
        while (done_cnt < target && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk({tag, " completion count"}, done_cnt, target);
        repeat (2) @(negedge clk);
    endtask

    // R12 / R1 / R8: reset state and idle polling with nothing ready.
    task automatic t_reset();
        @(negedge clk);
        chk("R12 fifo_wr after reset", fifo_wr, 0);
        chk("R12 bd_done after reset", bd_done, 0);
        chk("R12 ext_req after reset", ext_req, 0);
        chk("R12 underrun after reset", underrun, 0);
        repeat (40) @(negedge clk);
        chk("R1 no start while not ready", done_cnt, 0);
        chk("R1 no write-back while not ready", wb_cnt, 0);
        chk("R8 idle polling raises no underrun", ur_cnt, 0);
        chk("R1 no bytes while not ready", rx_b.size(), 0);
    endtask

    // R2 / R3 / R5 / R7: internal single-entry frame, odd start offset, junk high bits.
    task automatic t_internal();
        int r0;
        r0 = rx_b.size();
        set_bd(0, 16'h8800, 16'd5, 16'h00AB, 16'hFA41);
        wait_done(1, "R1 entry 0");
        chk("R2 internal byte count", rx_b.size() - r0, 5);
        for (int k = 0; k < 5; k++) begin
            chk($sformatf("R3 internal byte %0d", k), rx_b[r0+k], ibyte(16'h0241 + k));
            chk($sformatf("R7 end marker byte %0d", k), rx_l[r0+k], (k == 4) ? 1 : 0);
        end
        chk("R5 status write-back entry 0", mem[0], 16'h0800);
    endtask

    // R4 / R10 / R5: external buffer with function code written while idle.
    task automatic t_external();
        int r0;
        int x0;
        r0 = rx_b.size();
        x0 = xa_q.size();
        fc_write(3'd5);
        set_bd(1, 16'h9800, 16'd3, 16'hFF12, 16'h3456);
        wait_done(2, "R4 entry 1");
        chk("R4 external access count", xa_q.size() - x0, 3);
        for (int k = 0; k < 3; k++) begin
            chk($sformatf("R4 external address %0d", k), xa_q[x0+k], 24'h123456 + k);
            chk($sformatf("R10 idle write applied %0d", k), xf_q[x0+k], 3'd5);
            chk($sformatf("R2 external byte %0d", k), rx_b[r0+k], (8'h56 + k) ^ 8'h5A);
        end
        chk("R5 status write-back entry 1", mem[4], 16'h1800);
    endtask

    // R7 / R11: three-entry frame, final entry linked late while the FIFO stalls.
    task automatic t_late_link();
        int r0;
        r0 = rx_b.size();
        fifo_full = 1'b1;
        set_bd(2, 16'h8000, 16'd2, 16'h0000, 16'h0300);
        set_bd(3, 16'h8000, 16'd2, 16'h0000, 16'h0302);
        repeat (20) @(negedge clk);
        set_bd(4, 16'h8800, 16'd2, 16'h0000, 16'h0304);
        repeat (5) @(negedge clk);
        chk("R11 no push while full", rx_b.size() - r0, 0);
        fifo_full = 1'b0;
        wait_done(5, "R7 late-linked frame");
        chk("R7 frame byte count", rx_b.size() - r0, 6);
        for (int k = 0; k < 6; k++) begin
            chk($sformatf("R7 frame byte %0d", k), rx_b[r0+k], ibyte(16'h0300 + k));
            chk($sformatf("R7 frame end marker %0d", k), rx_l[r0+k], (k == 5) ? 1 : 0);
        end
        chk("R8 late link without underrun", ur_cnt, 0);
        chk("R5 non-last write-back entry 2", mem[8], 16'h0000);
        chk("R5 last write-back entry 4", mem[16], 16'h0800);
    endtask

    // R8 / R9 / R6: underrun, discard to the last entry, natural wrap after entry 7.
    task automatic t_underrun();
        int r0;
        r0 = rx_b.size();
        set_bd(5, 16'h8000, 16'd2, 16'h0000, 16'h0310);
        wait_done(6, "R8 entry 5");
        repeat (40) @(negedge clk);
        chk("R8 underrun flagged once", ur_cnt, 1);
        chk("R8 bytes before underrun", rx_b.size() - r0, 2);
        chk("R5 entry 5 sent cleanly", mem[20], 16'h0000);
        r0 = rx_b.size();
        set_bd(6, 16'h8000, 16'd3, 16'h0000, 16'h0320);
        set_bd(7, 16'h8800, 16'd2, 16'h0000, 16'h0330);
        wait_done(8, "R9 discarded entries");
        chk("R9 discarded entries push nothing", rx_b.size() - r0, 0);
        chk("R9 entry 6 marked", mem[24], 16'h0002);
        chk("R9 entry 7 marked", mem[28], 16'h0802);
        chk("R9 no second underrun", ur_cnt, 1);
        r0 = rx_b.size();
        set_bd(0, 16'hA800, 16'd1, 16'h0000, 16'h0340);
        wait_done(9, "R6 entry 0 after entry 7");
        chk("R6 natural wrap byte", rx_b[r0], ibyte(16'h0340));
        chk("R9 normal after discard", mem[0], 16'h2800);
        r0 = rx_b.size();
        set_bd(0, 16'hA800, 16'd1, 16'h0000, 16'h0342);
        wait_done(10, "R6 wrap bit");
        chk("R6 wrap bit byte", rx_b[r0], ibyte(16'h0342));
    endtask

    // R10: function-code write during a transfer is dropped, later idle write taken.
    task automatic t_fc_busy();
        int x0;
        x0 = xa_q.size();
        fifo_full = 1'b1;
        set_bd(0, 16'hB800, 16'd2, 16'h0000, 16'h0040);
        repeat (20) @(negedge clk);
        fc_write(3'd2);
        repeat (5) @(negedge clk);
        fifo_full = 1'b0;
        wait_done(11, "R10 busy entry");
        chk("R10 busy access count", xa_q.size() - x0, 2);
        for (int k = 0; k < 2; k++) begin
            chk($sformatf("R10 busy write ignored %0d", k), xf_q[x0+k], 3'd5);
            chk($sformatf("R4 busy address %0d", k), xa_q[x0+k], 24'h000040 + k);
        end
        x0 = xa_q.size();
        fc_write(3'd2);
        set_bd(0, 16'hB800, 16'd1, 16'h0000, 16'h0050);
        wait_done(12, "R10 idle entry");
        chk("R10 idle write taken", xf_q[x0], 3'd2);
        chk("R11 no push while full overall", bad_push, 0);
    endtask

    initial begin
        rst_n = 1'b0; tb_we = 1'b0; tb_addr = '0; tb_wdata = '0;
        fifo_full = 1'b0; fc_we = 1'b0; fc_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_internal();
        t_external();
        t_late_link();
        t_underrun();
        t_fc_busy();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule